// File: doc/BRIEF.md
# Registered OR-Combined Register Readback Bus

This block forms the read-data path for a group of memory-mapped registers in a device that has no internal tristate buffers. Each readable source has its own read enable. A source whose enable is low is forced to zeros. Each source's gated value is captured in its own pipeline register. The registered values are then ORed bit by bit into a single read bus. The result is a short combinational path in front of the OR tree, at the cost of one cycle of read latency.

Sources may be narrower than the bus. Each source has its own native width, set by a parameter, and its bits above that width read as zero. A separate write path gives each writable register a plain clock enable from a shared write-data bus. There is no multiplexing on the write side.

Top module: `regread_or_bus`

## Requirements
- R1: A source whose read enable is low contributes zero to the read bus, whatever its data input carries.
- R2: With exactly one read enable high at a rising edge, `rd_data` equals that source's masked data from that edge onward, until the next edge (one cycle of latency).
- R3: If no read enable is high at a rising edge, `rd_data` is all zeros after that edge.
- R4: While `rst_n` is low, `rd_data` and every `cfg_q` field are zero, and they clear at once without waiting for a clock edge.
- R5: Source i has native width `SRC_W[i*32 +: 32]` (defaults: source 0 is 16 bits, source 1 is 8 bits, source 2 is 12 bits). Bits of `rd_data` at and above that width read zero whenever that source is the one selected.
- R6: If several read enables are high together, which is a protocol violation, `rd_data` one cycle later is the bitwise OR of the masked data of all the selected sources.
- R7: When `wr_en[i]` is high at a rising edge, field i of `cfg_q` loads `wr_data`, masked to the native width of source i.
- R8: When `wr_en[i]` is low, field i of `cfg_q` holds its value, even while other fields are being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | N*W | Source i data in bits [i*W +: W], padded to the bus width |
| rd_en | input | N | Per-source read enable, at most one high |
| rd_data | output | W | Registered OR-combined read data |
| wr_data | input | W | Shared write-data bus |
| wr_en | input | N | Per-register write clock enable |
| cfg_q | output | N*W | Writable register contents, field i in bits [i*W +: W] |

## Verification
The condition hardest to reach from the ports is a multi-enable cycle that falls between two single-source reads. Such a cycle shows whether a stale pipeline register leaks into the OR result. To reach it, the random stimulus sets the data of every source, including the unselected ones, to random values with high bits set. Overlapping enable vectors are mixed in among single and idle cycles, so every register is exercised while its neighbours carry live data. A mid-stream reset, applied between edges, exercises the asynchronous clear.

// File: rtl/regread_or_bus.sv
module regread_or_bus #(
  parameter int N = 3,
  parameter int W = 16,
  parameter logic [N*32-1:0] SRC_W = {32'd12, 32'd8, 32'd16}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] src_data,
  input  logic [N-1:0]   rd_en,
  output logic [W-1:0]   rd_data,
  input  logic [W-1:0]   wr_data,
  input  logic [N-1:0]   wr_en,
  output logic [N*W-1:0] cfg_q
);

  logic [W-1:0] stage [N];
  logic [W-1:0] acc;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int SW = int'(SRC_W[i*32 +: 32]);
    localparam logic [W-1:0] MSK = {W{1'b1}} >> (W - SW);

    wire [W-1:0] gated = rd_en[i] ? (src_data[i*W +: W] & MSK) : '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= gated;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        cfg_q[i*W +: W] <= '0;
      else if (wr_en[i]) cfg_q[i*W +: W] <= wr_data & MSK;

    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rd_en) == 1 && rd_en[i]) |=> rd_data == ($past(src_data[i*W +: W]) & MSK));

    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rd_en) == 1 && rd_en[i]) |=> (rd_data & ~MSK) == '0);

    assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> cfg_q[i*W +: W] == ($past(wr_data) & MSK));

    assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[i] |=> $stable(cfg_q[i*W +: W]));
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) acc |= stage[i];
  end

  assign rd_data = acc;

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en == '0) |=> rd_data == '0);

  assert_reset_clear_R4: assert property (@(posedge clk)
    !rst_n |-> (rd_data == '0 && cfg_q == '0));

endmodule

// File: tb/regread_or_bus_bench.sv
module regread_or_bus_bench;
  localparam int N = 3;
  localparam int W = 16;
  localparam logic [W-1:0] M0 = 16'hFFFF, M1 = 16'h00FF, M2 = 16'h0FFF;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [N*W-1:0] src_data = '0;
  logic [N-1:0]   rd_en = '0;
  logic [W-1:0]   rd_data;
  logic [W-1:0]   wr_data = '0;
  logic [N-1:0]   wr_en = '0;
  logic [N*W-1:0] cfg_q;

  int compared = 0, mismatched = 0, violations = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  bit           done = 0;

  regread_or_bus u_regread_or_bus (.*);

  always #2 clk = ~clk;

  function automatic logic [W-1:0] msk(int i);
    return (i == 0) ? M0 : (i == 1) ? M1 : M2;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_read(logic [N-1:0] en, logic [N*W-1:0] d);
    logic [W-1:0] e = '0;
    string tag;
    @(negedge clk);
    rd_en = en; src_data = d;
    for (int i = 0; i < N; i++) if (en[i]) e |= d[i*W +: W] & msk(i);
    if ($countones(en) > 1) begin
      violations++;
      $display("NOTE protocol violation: rd_en=%b", en);
      tag = "R6";
    end else if (en == '0) tag = "R3";
    else tag = "R2/R1/R5";
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic drain();
    @(negedge clk); rd_en = '0;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1;
    check("R4 reset rd_data", rd_data, '0);
    check("R4 reset cfg", cfg_q[W-1:0] | cfg_q[2*W-1:W] | cfg_q[3*W-1:2*W], '0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    drive_read(3'b001, {16'hAAAA, 16'h5555, 16'hBEEF});
    drive_read(3'b010, {16'hAAAA, 16'hFFFF, 16'hBEEF});
    drive_read(3'b100, {16'hFFFF, 16'hFFFF, 16'hFFFF});
    drive_read(3'b000, {16'hFFFF, 16'hFFFF, 16'hFFFF});
    drive_read(3'b011, {16'h0000, 16'h1234, 16'h4321});
    drive_read(3'b111, {16'hF00F, 16'h0FF0, 16'h0000});
    drive_read(3'b001, {16'hFFFF, 16'hFFFF, 16'h0001});

    for (int k = 0; k < 400; k++) begin
      int pick = $urandom_range(0, 9);
      logic [N-1:0] en;
      en = (pick < 3) ? N'(1 << pick) : (pick < 5) ? '0 : (pick < 6) ? N'($urandom) : N'(1 << (pick % 3));
      drive_read(en, {N{16'($urandom)}} ^ {$urandom, $urandom});
    end
    drain();

    rd_en = 3'b010; src_data = {3{16'h00C3}};
    @(posedge clk); #1;
    check("R2 before reset", rd_data, 16'h00C3);
    rst_n = 0; #0.5;
    check("R4 async clear", rd_data, '0);
    rd_en = '0;
    @(negedge clk); rst_n = 1;

    @(negedge clk); wr_en = 3'b111; wr_data = 16'hFFFF;
    @(negedge clk); wr_en = '0;
    check("R7 write w0", cfg_q[W-1:0], 16'hFFFF);
    check("R7 write w1 masked", cfg_q[2*W-1:W], 16'h00FF);
    check("R7 write w2 masked", cfg_q[3*W-1:2*W], 16'h0FFF);
    wr_en = 3'b010; wr_data = 16'h1234;
    @(negedge clk); wr_en = '0; wr_data = 16'hDEAD;
    check("R7 write w1", cfg_q[2*W-1:W], 16'h0034);
    check("R8 hold w0", cfg_q[W-1:0], 16'hFFFF);
    check("R8 hold w2", cfg_q[3*W-1:2*W], 16'h0FFF);
    repeat (2) @(negedge clk);
    check("R8 hold idle w1", cfg_q[2*W-1:W], 16'h0034);

    done = 1;
    $display("protocol violations flagged: %0d", violations);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule